// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one 16-bit channel that sits beside a timer counter it does not own. A mode bit in its control register picks the role of its single value register. As a compare register, the value is checked against the counter value. When the counter moves onto that value, the channel raises a one-clock interrupt request. As a capture register, the value register latches the counter value when a chosen edge appears on an external input pin. The pin is first passed through a synchronizer.

Software reaches the channel through a plain register port. A write takes effect on the clock edge that samples it. A read returns its data one clock later, flagged by a valid strobe. There is no back-pressure on either side, because the timer moves on every clock whether or not software keeps up. The counter value and its overflow, clear and stop events come from the timer as plain level and pulse inputs.

A compare value of zero is handled apart from the others. It matches only when the timer reports an overflow or a clear, so starting the count from zero gives no interrupt.

Top module: `tmr_capcmp`

## Requirements
- R1: After reset the value register reads 0x0000, the control register reads 0x0000 (compare mode), and `irq` is low.
- R2: A write with `wr_addr`=0 loads the value register, and a write with `wr_addr`=1 loads control. The control word is bit 0 = mode (0 compare, 1 capture) and bits 2:1 = edge code, and it reads back zero-extended. `rd_data` and `rd_vld` appear on the clock after the `rd_en` cycle.
- R3: In compare mode with a nonzero value, `irq` pulses for one clock, one clock after `cnt_val` changes to equal the value. A counter that stays at that value gives no further pulses, and the value does not change unless it is written.
- R4: In compare mode with value 0x0000, `irq` pulses only for a cycle in which `cnt_val` is 0 and `cnt_ovf` or `cnt_clr` is high. Counting that starts at zero with neither event gives no pulse.
- R5: In capture mode, the edge code selects the trigger: 00 = falling edge, 01 = rising edge, 11 = both edges of `pin_in`. On a trigger, the value register takes `cnt_val` and `irq` pulses once. Edges that the code does not select are ignored.
- R6: Edge code 10 counts as no valid edge. Pin activity then leaves the value register unchanged and raises no `irq`.
- R7: A capture trigger that arrives while `cnt_stop` is high keeps the previous value and raises no `irq`.
- R8: A read in the same cycle as a capture returns the value held before the capture, and the capture is still stored.
- R9: In compare mode, `pin_in` has no effect. In capture mode, counter values equal to the stored value raise no `irq`.
- R10: A new compare value written while the counter runs is matched from then on, and the old value no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 value, 1 control |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | Read target: 0 value, 1 control |
| rd_data | output | 16 | Read data, valid with rd_vld |
| rd_vld | output | 1 | Read data valid, one clock after rd_en |
| cnt_val | input | 16 | Current timer counter value |
| cnt_ovf | input | 1 | Counter overflowed this cycle |
| cnt_clr | input | 1 | Counter cleared this cycle |
| cnt_stop | input | 1 | Counter stopped |
| pin_in | input | 1 | Raw external timer input pin |
| irq | output | 1 | Interrupt request pulse |

## Verification
A synchronizer or edge-history flop holding the wrong state shows up within about three clocks of a pin change. The symptom is a missing or extra `irq` pulse, or a value register that read-back shows unchanged or holding the wrong count. A wrong copy of the previous counter value shows up the first time the counter reaches the compare value or sits on it: the pulse count is then off by one. A corrupted zero-value path fires at the start of counting, or stays silent on an overflow, and shows up within the next counter event.

// File: rtl/tmr_capcmp_pkg.sv
package tmr_capcmp_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    edge_sel_e edge_sel;
    logic      cap_mode;
  } ctl_t;

  localparam int  CTL_W    = $bits(ctl_t);
  localparam logic ADDR_VAL = 1'b0;
  localparam logic ADDR_CTL = 1'b1;
endpackage

// File: rtl/tmr_capcmp_edge.sv
module tmr_capcmp_edge
  import tmr_capcmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_in,
  input  edge_sel_e sel,
  output logic      trig
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   samp;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign samp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= samp;
  end

  always_comb begin
    unique case (sel)
      EDGE_FALL: trig = ~samp & last_q;
      EDGE_RISE: trig = samp & ~last_q;
      EDGE_BOTH: trig = samp ^ last_q;
      default:   trig = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_capcmp_match.sv
module tmr_capcmp_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             ovf,
  input  logic             clr,
  output logic             hit
);
  logic [CNT_W-1:0] prev_q;
  logic             eq;
  logic             zero_cmp;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cnt;
  end

  assign eq       = (cnt == cmp);
  assign zero_cmp = (cmp == '0);

  always_comb begin
    if (!en)           hit = 1'b0;
    else if (zero_cmp) hit = eq & (ovf | clr);
    else               hit = eq & (cnt != prev_q);
  end

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $stable(cnt) && cmp != '0) |-> !hit); // R3
endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp
  import tmr_capcmp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_vld,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_ovf,
  input  logic             cnt_clr,
  input  logic             cnt_stop,
  input  logic             pin_in,
  output logic             irq
);
  localparam int PAD_W = CNT_W - CTL_W;

  ctl_t             ctl_q;
  logic [CNT_W-1:0] val_q;
  logic             trig;
  logic             hit;
  logic             cap_fire;
  logic             wr_val;
  logic             wr_ctl;

  assign wr_val = wr_en && (wr_addr == ADDR_VAL);
  assign wr_ctl = wr_en && (wr_addr == ADDR_CTL);

  tmr_capcmp_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .sel    (ctl_q.edge_sel),
    .trig   (trig)
  );

  tmr_capcmp_match #(.CNT_W(CNT_W)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (~ctl_q.cap_mode),
    .cnt   (cnt_val),
    .cmp   (val_q),
    .ovf   (cnt_ovf),
    .clr   (cnt_clr),
    .hit   (hit)
  );

  assign cap_fire = ctl_q.cap_mode & trig & ~cnt_stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      val_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl_q.cap_mode <= wr_data[0];
        ctl_q.edge_sel <= edge_sel_e'(wr_data[2:1]);
      end
      if (wr_val)        val_q <= wr_data;
      else if (cap_fire) val_q <= cnt_val;
      irq <= hit | cap_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) begin
        if (rd_addr == ADDR_CTL) rd_data <= {{PAD_W{1'b0}}, ctl_q};
        else                     rd_data <= val_q;
      end
    end
  end

  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.cap_mode && !wr_val) |=> $stable(val_q)); // R3
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.cap_mode && val_q == '0 && !cnt_ovf && !cnt_clr) |=> !irq); // R4
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && !wr_val) |=> (val_q == $past(cnt_val) && irq)); // R5
  AST_PROHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.cap_mode && ctl_q.edge_sel == EDGE_NONE && !wr_val) |=> ($stable(val_q) && !irq)); // R6
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.cap_mode && cnt_stop && !wr_val) |=> ($stable(val_q) && !irq)); // R7
endmodule

// File: tb/tmr_capcmp_bench.sv
module tmr_capcmp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_addr = 1'b0, rd_en = 1'b0, rd_addr = 1'b0;
  logic [15:0] wr_data = '0, cnt_val = '0;
  logic        cnt_ovf = 1'b0, cnt_clr = 1'b0, cnt_stop = 1'b0, pin_in = 1'b0;
  logic [15:0] rd_data;
  logic        rd_vld, irq;

  int n_chk = 0, n_fail = 0, irq_seen = 0, irq_base = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  tmr_capcmp u_tmr_capcmp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_vld(rd_vld),
    .cnt_val(cnt_val), .cnt_ovf(cnt_ovf), .cnt_clr(cnt_clr), .cnt_stop(cnt_stop),
    .pin_in(pin_in), .irq(irq)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && irq) irq_seen++;

  always @(negedge clk) begin
    if (rd_vld) begin
      if (exp_q.size() == 0) chk("R2 unexpected read", 1, 0);
      else chk(tag_q.pop_front(), int'(rd_data), int'(exp_q.pop_front()));
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic a, logic [15:0] exp, string tag);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic irq_chk(int exp, string tag);
    idle(2);
    chk(tag, irq_seen - irq_base, exp);
    irq_base = irq_seen;
  endtask

  task automatic count(int from, int to);
    for (int v = from; v <= to; v++) begin @(negedge clk); cnt_val = 16'(v); end
  endtask

  task automatic pin(logic v);
    @(negedge clk); pin_in = v; idle(4);
  endtask

  task automatic event_zero(bit use_ovf);
    @(negedge clk); cnt_val = '0; cnt_ovf = use_ovf; cnt_clr = !use_ovf;
    @(negedge clk); cnt_ovf = 1'b0; cnt_clr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    chk("R1 irq low after reset", int'(irq), 0);
    rd(1'b0, 16'h0000, "R1 value reset");
    rd(1'b1, 16'h0000, "R1 control reset");
    wr(1'b0, 16'h00A5); rd(1'b0, 16'h00A5, "R2 value readback");
    wr(1'b1, 16'hFFF6); rd(1'b1, 16'h0006, "R2 control readback");
    wr(1'b1, 16'h0000);

    // R3 compare nonzero
    wr(1'b0, 16'd5); irq_base = irq_seen;
    count(0, 9); irq_chk(1, "R3 single match");
    count(3, 5); idle(6); irq_chk(1, "R3 held on match no repeat");
    rd(1'b0, 16'd5, "R3 value held");

    // R4 zero compare
    wr(1'b0, 16'd0); count(0, 0); count(1, 4); irq_chk(0, "R4 no irq at count start");
    event_zero(1'b1); irq_chk(1, "R4 overflow match");
    count(1, 4); event_zero(1'b0); irq_chk(1, "R4 clear match");

    // R10 rewrite while running
    wr(1'b0, 16'd5); count(1, 3); wr(1'b0, 16'd8); count(4, 9);
    irq_chk(1, "R10 new value only");

    // R9 pin ignored in compare mode
    pin(1'b1); pin(1'b0); irq_chk(0, "R9 pin ignored compare");
    rd(1'b0, 16'd8, "R9 value untouched by pin");

    // R5 capture rising
    cnt_val = 16'h1234; wr(1'b1, 16'h0003); irq_base = irq_seen;
    pin(1'b1); irq_chk(1, "R5 rise capture irq");
    rd(1'b0, 16'h1234, "R5 rise captured");
    cnt_val = 16'h2222; pin(1'b0); irq_chk(0, "R5 fall ignored in rise mode");
    rd(1'b0, 16'h1234, "R5 value kept");
    // falling
    wr(1'b1, 16'h0001); pin(1'b1); cnt_val = 16'h3333; pin(1'b0);
    irq_chk(1, "R5 fall mode one irq");
    rd(1'b0, 16'h3333, "R5 fall captured");
    // both
    wr(1'b1, 16'h0007); cnt_val = 16'h4444; pin(1'b1);
    rd(1'b0, 16'h4444, "R5 both rise captured");
    cnt_val = 16'h5555; pin(1'b0);
    rd(1'b0, 16'h5555, "R5 both fall captured");
    irq_chk(2, "R5 both edges two irqs");

    // R6 prohibited code
    wr(1'b1, 16'h0005); cnt_val = 16'h6666; pin(1'b1); pin(1'b0);
    irq_chk(0, "R6 code 10 no irq");
    rd(1'b0, 16'h5555, "R6 code 10 no capture");

    // R7 stop coincidence
    wr(1'b1, 16'h0003); cnt_val = 16'h7777; cnt_stop = 1'b1; pin(1'b1); cnt_stop = 1'b0;
    irq_chk(0, "R7 stop no irq");
    rd(1'b0, 16'h5555, "R7 stop keeps value");
    pin(1'b0);

    // R8 read coinciding with capture
    cnt_val = 16'h8888;
    @(negedge clk); pin_in = 1'b1; @(negedge clk);
    rd(1'b0, 16'h5555, "R8 coincident read old");
    idle(3); rd(1'b0, 16'h8888, "R8 capture stored");
    irq_chk(1, "R8 capture irq");

    // R9 no compare irq in capture mode
    count(16'h8880, 16'h8890); irq_chk(0, "R9 capture mode no compare");

    idle(4);
    chk("R2 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule